// File: doc/BRIEF.md
# IO Configuration Bring-Up Sequencer

This block drives the handful of control lines that move a peripheral IO corner from its safe power-on defaults to a fully configured, enabled state. Out of reset every control line is low, so the pads keep their hardware defaults. A single start pulse then walks the controls through four fixed output images. Each of the first three images is held for a programmable settle interval before the next one is applied: a 3-bit drive-select code set to all ones with the core-ready line raised, then the code cleared, then the configuration-valid line raised, then the pad-enable line raised.

One cycle after the last image is applied, a done flag rises. It stays high until a new start or an abort. A 14-bit status word mirrors the current output image at fixed bit positions, so a neighbouring block can decode it. An abort input returns the sequence to idle at any point. A start that arrives while the sequence is running has no effect.

Top module: `io_bringup_seq`

## Requirements
- R1: While the asynchronous active-low reset is asserted, sel_code_o, core_ready_o, cfg_valid_o, pad_en_o, done_o and status_o are all zero, without waiting for a clock edge. After reset they stay zero until a start is accepted.
- R2: A start sampled in idle applies the first image at the next edge: sel_code_o=3'b111, core_ready_o=1, cfg_valid_o=0, pad_en_o=0.
- R3: The second image has sel_code_o=3'b000 and core_ready_o=1, with cfg_valid_o=0 and pad_en_o=0.
- R4: The third image raises cfg_valid_o, with sel_code_o=3'b000 and core_ready_o=1 held and pad_en_o=0.
- R5: The fourth image raises pad_en_o, with core_ready_o=1, cfg_valid_o=1 and sel_code_o=3'b000.
- R6: Each of the first three images lasts exactly SETTLE_CYCLES clock cycles. With the start sampled at edge k, the images begin after edges k, k+S, k+2S and k+3S.
- R7: status_o bit 13 is pad_en_o, bit 12 is cfg_valid_o, bit 11 is core_ready_o, bits 10:8 are sel_code_o, and bits 7:0 read zero.
- R8: done_o rises one cycle after the fourth image is applied, after edge k+3S+1, and stays high with the fourth image held. A start sampled while done is high clears done and restarts at the first image.
- R9: A start sampled while any of the four images is being applied, before done, does not change the sequence or its timing.
- R10: An abort sampled in any non-idle state returns all outputs and done to zero at the next edge. Abort takes priority over a start in the same cycle. In idle, abort has no effect.
- R11: cfg_valid_o is never high unless sel_code_o is 3'b000 and core_ready_o is high. pad_en_o is never high unless cfg_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start request, sampled on the rising edge |
| abort_i | input | 1 | Return to idle, sampled on the rising edge |
| sel_code_o | output | 3 | Drive-select code to the IO corner |
| core_ready_o | output | 1 | Core-ready control line |
| cfg_valid_o | output | 1 | Configuration-valid control line |
| pad_en_o | output | 1 | Pad enable control line |
| done_o | output | 1 | Sequence complete |
| status_o | output | 14 | Image of the control lines at fixed bit positions |

## Verification
All results follow arithmetically from the number of edges since the start was sampled at edge k. After edge k+t, the image index is t divided by SETTLE_CYCLES, capped at three, and done is due once t reaches 3S+1. Abort and restart take effect at the very next edge, and reset clears the outputs within a fraction of a cycle. The bench runs two instances side by side, one with a settle of three cycles and one with a settle of one cycle. It drives inputs on falling edges and compares the full status word and done against the computed value at every falling edge, so each output is checked in the cycle it is due and in every cycle it is held.

// File: rtl/iobs_pkg.sv
package iobs_pkg;
  localparam int CODE_W   = 3;
  localparam int STATUS_W = 14;
  localparam int CODE_LSB = 8;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ARM   = 3'd1,
    PH_CLEAR = 3'd2,
    PH_LOAD  = 3'd3,
    PH_OPEN  = 3'd4,
    PH_DONE  = 3'd5
  } phase_e;

  typedef struct packed {
    logic              pad_en;
    logic              cfg_valid;
    logic              core_ready;
    logic [CODE_W-1:0] sel_code;
  } ctl_t;
endpackage

// File: rtl/iobs_rst_sync.sv
module iobs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/iobs_settle_timer.sv
module iobs_settle_timer #(
  parameter int SETTLE_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | (run_i & (cnt_q != '0));
    cnt_d  = load_i ? RELOAD : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/iobs_phase_fsm.sv
module iobs_phase_fsm
  import iobs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   abort_i,
  input  logic   expired_i,
  output phase_e phase_o,
  output logic   load_o,
  output logic   run_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (start_i && !abort_i) phase_d = PH_ARM;
      PH_ARM:   if (abort_i) phase_d = PH_IDLE; else if (expired_i) phase_d = PH_CLEAR;
      PH_CLEAR: if (abort_i) phase_d = PH_IDLE; else if (expired_i) phase_d = PH_LOAD;
      PH_LOAD:  if (abort_i) phase_d = PH_IDLE; else if (expired_i) phase_d = PH_OPEN;
      PH_OPEN:  phase_d = abort_i ? PH_IDLE : PH_DONE;
      PH_DONE:  if (abort_i) phase_d = PH_IDLE; else if (start_i) phase_d = PH_ARM;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    load_o = (phase_d != phase_q) &&
             (phase_d == PH_ARM || phase_d == PH_CLEAR || phase_d == PH_LOAD);
    run_o  = (phase_q == PH_ARM || phase_q == PH_CLEAR || phase_q == PH_LOAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/iobs_ctl_decode.sv
module iobs_ctl_decode
  import iobs_pkg::*;
(
  input  phase_e phase_i,
  output ctl_t   ctl_o,
  output logic   done_o
);
  always_comb begin
    ctl_o  = '0;
    done_o = 1'b0;
    unique case (phase_i)
      PH_IDLE:  ctl_o = '0;
      PH_ARM: begin
        ctl_o.sel_code   = '1;
        ctl_o.core_ready = 1'b1;
      end
      PH_CLEAR: ctl_o.core_ready = 1'b1;
      PH_LOAD: begin
        ctl_o.core_ready = 1'b1;
        ctl_o.cfg_valid  = 1'b1;
      end
      PH_OPEN, PH_DONE: begin
        ctl_o.core_ready = 1'b1;
        ctl_o.cfg_valid  = 1'b1;
        ctl_o.pad_en     = 1'b1;
        done_o           = (phase_i == PH_DONE);
      end
      default: ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/io_bringup_seq.sv
module io_bringup_seq
  import iobs_pkg::*;
#(
  parameter int SETTLE_CYCLES = 10,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                abort_i,
  output logic [CODE_W-1:0]   sel_code_o,
  output logic                core_ready_o,
  output logic                cfg_valid_o,
  output logic                pad_en_o,
  output logic                done_o,
  output logic [STATUS_W-1:0] status_o
);
  logic   rst_int_n;
  logic   tmr_load, tmr_run, tmr_expired;
  phase_e phase;
  ctl_t   ctl;

  iobs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  iobs_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (tmr_load),
    .run_i     (tmr_run),
    .expired_o (tmr_expired)
  );

  iobs_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start_i),
    .abort_i   (abort_i),
    .expired_i (tmr_expired),
    .phase_o   (phase),
    .load_o    (tmr_load),
    .run_o     (tmr_run)
  );

  iobs_ctl_decode u_decode (
    .phase_i (phase),
    .ctl_o   (ctl),
    .done_o  (done_o)
  );

  assign sel_code_o   = ctl.sel_code;
  assign core_ready_o = ctl.core_ready;
  assign cfg_valid_o  = ctl.cfg_valid;
  assign pad_en_o     = ctl.pad_en;
  assign status_o     = {ctl, {CODE_LSB{1'b0}}};
endmodule

// File: rtl/iobs_checker.sv
module iobs_checker
  import iobs_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                abort_i,
  input logic [CODE_W-1:0]   sel_code_o,
  input logic                core_ready_o,
  input logic                cfg_valid_o,
  input logic                pad_en_o,
  input logic                done_o,
  input logic [STATUS_W-1:0] status_o
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (status_o == '0 && !done_o && !core_ready_o && !cfg_valid_o && !pad_en_o)); // R1
  AST_CODE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n) (sel_code_o == '0 || sel_code_o == '1)); // R2
  AST_VALID_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(cfg_valid_o) |-> ($past(core_ready_o) && $past(sel_code_o) == '0)); // R4
  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) status_o[CODE_LSB-1:0] == '0); // R7
  AST_DONE_FULL_IMAGE: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (pad_en_o && cfg_valid_o && core_ready_o)); // R8
  AST_DONE_LAGS_PAD: assert property (@(posedge clk) disable iff (!rst_n) $rose(done_o) |-> $past(pad_en_o)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (pad_en_o && !done_o && start_i && !abort_i) |=> done_o); // R9
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (abort_i && core_ready_o) |=> (status_o == '0 && !done_o)); // R10
  AST_VALID_ORDER: assert property (@(posedge clk) disable iff (!rst_n) cfg_valid_o |-> (core_ready_o && sel_code_o == '0)); // R11
  AST_PAD_ORDER: assert property (@(posedge clk) disable iff (!rst_n) pad_en_o |-> cfg_valid_o); // R11
endmodule

bind io_bringup_seq iobs_checker u_iobs_checker (.*);

// File: tb/io_bringup_seq_bench.sv
module io_bringup_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n, start, abort;
  logic [2:0]  code_a, code_b;
  logic        core_a, valid_a, pad_a, done_a;
  logic        core_b, valid_b, pad_b, done_b;
  logic [13:0] st_a, st_b;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  localparam int SA = 3;
  localparam int SB = 1;

  always #10 clk = ~clk;

  io_bringup_seq #(.SETTLE_CYCLES(SA)) u_io_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
    .sel_code_o(code_a), .core_ready_o(core_a), .cfg_valid_o(valid_a),
    .pad_en_o(pad_a), .done_o(done_a), .status_o(st_a));

  io_bringup_seq #(.SETTLE_CYCLES(SB)) u_fast (
    .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
    .sel_code_o(code_b), .core_ready_o(core_b), .cfg_valid_o(valid_b),
    .pad_en_o(pad_b), .done_o(done_b), .status_o(st_b));

  // {done, status} expected t edges after the start edge
  function automatic logic [14:0] expect_img(int s, int t);
    int p = t / s;
    logic [2:0] c = (p == 0) ? 3'b111 : 3'b000;
    logic v = (p >= 2);
    logic pe = (p >= 3);
    logic d = (t >= 3 * s + 1);
    return {d, pe, v, 1'b1, c, 8'h00};
  endfunction

  task automatic cmp(string tag, logic [14:0] act, logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_pair(string tag, int t);
    cmp({tag, " slow"}, {done_a, st_a}, expect_img(SA, t));
    cmp({tag, " fast"}, {done_b, st_b}, expect_img(SB, t));
    // field positions of status against the individual ports (R7)
    cmp("R7 fields slow", {1'b0, pad_a, valid_a, core_a, code_a, 8'h00}, {1'b0, st_a});
    cmp("R7 fields fast", {1'b0, pad_b, valid_b, core_b, code_b, 8'h00}, {1'b0, st_b});
  endtask

  task automatic check_idle(string tag);
    cmp({tag, " slow"}, {done_a, st_a}, 15'h0);
    cmp({tag, " fast"}, {done_b, st_b}, 15'h0);
  endtask

  // start sampled on the next rising edge; returns at the falling edge, t=0
  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; abort = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 after release");

    // full sequence and done hold: R2 R3 R4 R5 R6 R7 R8
    pulse_start();
    for (int t = 0; t <= 20; t++) begin
      check_pair("R2/R3/R4/R5/R6/R8 sweep", t);
      if (t < 20) @(negedge clk);
    end

    // restart from done, then a mid-run start that must be ignored (R8, R9)
    pulse_start();
    for (int t = 0; t <= 14; t++) begin
      check_pair("R8/R9 restart", t);
      if (t == 2) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end else if (t < 14) begin
        @(negedge clk);
      end
    end

    // abort mid-run (slow in second image, fast in fourth) R10
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check_idle("R10 abort from done");
    pulse_start();
    for (int t = 0; t <= 3; t++) begin
      check_pair("R10 pre-abort", t);
      @(negedge clk);
    end
    check_pair("R10 pre-abort", 4);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check_idle("R10 abort mid-run");
    @(negedge clk);
    check_idle("R10 stays idle");
    abort = 1'b1;
    @(negedge clk);
    check_idle("R10 abort in idle");
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; abort = 1'b0;
    @(negedge clk);
    check_idle("R10 abort beats start");

    // asynchronous reset in the middle of a run (R1)
    pulse_start();
    repeat (5) @(negedge clk);
    check_pair("R1 before reset", 5);
    #5 rst_n = 1'b0;
    #1 check_idle("R1 async clear");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_idle("R1 idle after reset");
    end
    pulse_start();
    for (int t = 0; t <= 4; t++) begin
      check_pair("R2 after reset", t);
      @(negedge clk);
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end
endmodule